// File: doc/BRIEF.md
# Multilevel Interrupt Priority Controller

The controller receives requests from a set of interrupt sources. Each source is tagged with one of four levels: low, medium, high, or non-maskable. Every cycle it chooses one request to present to the processor. The processor is offered a vector index and a level, and it accepts the offer with an acknowledge. From that point the level counts as executing. While a level is executing, only strictly higher levels may interrupt it. A return strobe ends the innermost active level.

Each of the three maskable levels has its own enable. Non-maskable requests are always eligible. Within the medium, high and non-maskable levels, the source with the smallest index wins. Low-level requests are scanned starting from a software-writable pointer. In rotating mode, each accepted low-level request moves that pointer to the source after it. A small register window exposes three registers: the executing flags, the pointer and the control byte.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the control byte, the pointer and the executing flags are all zero, so only non-maskable requests can be granted.
- R2: A maskable request whose level enable is clear is never granted. A request at level 3 (non-maskable) is eligible whatever the enables hold.
- R3: A control write takes effect from the cycle after the write. In the cycle the write is presented, the previous enables still govern grants.
- R4: The highest eligible level wins (3 non-maskable, 2 high, 1 medium, 0 low). For levels 1 to 3, the lowest source index within the level wins.
- R5: A level is eligible only if neither it nor any level above it is executing.
- R6: When `gnt_ack_i` is high while a grant is offered, the granted level's executing flag is set on the next edge. The status register at address 0 shows the flags in bits 3..0 as non-maskable, high, medium, low. Its bits 7..4 read zero.
- R7: `reti_i` clears the highest executing flag. When it arrives together with an acknowledge, the clear acts on the old flags and the acknowledged level's flag is then set.
- R8: Low-level requests are searched from the pointer index upward, wrapping past N_SRC-1 to 0. This holds in both modes, so with the pointer at zero the lowest index wins.
- R9: With rotation on (control bit 7), acknowledging a low-level grant with index i loads the pointer with (i+1) mod N_SRC. With rotation off, acknowledges never change the pointer.
- R10: The pointer sits at address 1. A write stores the value modulo N_SRC (N_SRC is a power of two), and a read returns it zero-extended to 8 bits. The pointer keeps its value when rotation is turned off. A software write wins over a rotation update in the same cycle.
- R11: The control byte sits at address 2. Bit 7 enables rotation, and bits 2, 1 and 0 enable the high, medium and low levels. Bits 6..3 always read zero. Writes to addresses 0 and 3 change nothing, and address 3 reads zero.
- R12: The grant is combinational from the current requests and state. It appears in the same cycle as a qualifying request and stays offered until it is acknowledged or the request goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_SRC | Pending request per source |
| irq_lvl_i | input | 2*N_SRC | Level per source, 2 bits each (0 low, 1 medium, 2 high, 3 non-maskable) |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register address (0 status, 1 pointer, 2 control) |
| csr_wdata_i | input | 8 | Register write data |
| csr_rdata_o | output | 8 | Register read data for `csr_addr_i` |
| gnt_valid_o | output | 1 | A grant is offered |
| gnt_idx_o | output | IDX_W | Vector index of the offered grant |
| gnt_lvl_o | output | 2 | Level of the offered grant |
| gnt_ack_i | input | 1 | Processor accepts the offered grant |
| reti_i | input | 1 | Return from the innermost active level |

## Verification
The bench builds the controller with N_SRC = 8. With 8 sources, the rotating search wraps past the top index within a few grants. A pointer written near the top then shows the wrap from index 7 back to 0 with only a handful of requests. It also lets an acknowledge of source 7 carry the pointer back to zero. Eight sources are still enough to mix all four levels in one request pattern while nesting three levels deep.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MED = 2'd1,
    LVL_HI  = 2'd2,
    LVL_NMI = 2'd3
  } irq_lvl_e;

  localparam int NUM_LVL = 4;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_PTR    = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_ROT_BIT = 7;
endpackage

// File: rtl/irq_find_first.sv
module irq_find_first #(
  parameter  int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // circular scan beginning at start_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      automatic int c = (int'(start_i) + k) % N;
      if (!found_o && vec_i[c]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_prio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ack_i,
  input  logic [1:0]          ack_lvl_i,
  input  logic                reti_i,
  output logic [NUM_LVL-1:0]  act_o
);
  logic [NUM_LVL-1:0] act_q, act_d;

  always_comb begin
    automatic logic done = 1'b0;
    act_d = act_q;
    if (reti_i) begin
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
        if (!done && act_d[l]) begin
          act_d[l] = 1'b0;
          done     = 1'b1;
        end
      end
    end
    if (ack_i) act_d[ack_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  // R6
  ack_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> act_q[$past(ack_lvl_i)]);

  // R7
  reti_clears_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && act_q != '0) |=>
      ($countones(act_q) == $countones($past(act_q)) - 1));
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter  int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               ack_lo_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic [NUM_LVL-1:0] act_i,
  output logic [2:0]         en_o,
  output logic               rot_o,
  output logic [IDX_W-1:0]   ptr_o,
  output logic [7:0]         rdata_o
);
  logic [2:0]       en_q;
  logic             rot_q;
  logic [IDX_W-1:0] ptr_q;
  logic             ptr_wr, ctrl_wr;

  assign ptr_wr  = we_i && (addr_i == ADDR_PTR);
  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rot_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= wdata_i[2:0];
      rot_q <= wdata_i[CTRL_ROT_BIT];
    end
  end

  // software write beats rotation update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (ptr_wr)            ptr_q <= wdata_i[IDX_W-1:0];
    else if (ack_lo_i && rot_q) ptr_q <= ack_idx_i + IDX_W'(1);
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STATUS: rdata_o = {4'b0, act_i};
      ADDR_PTR:    rdata_o = 8'(ptr_q);
      ADDR_CTRL:   rdata_o = {rot_q, 4'b0, en_q};
      default:     rdata_o = 8'h00;
    endcase
  end

  assign en_o  = en_q;
  assign rot_o = rot_q;
  assign ptr_o = ptr_q;

  // R9
  ptr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_q && !ptr_wr) |=> $stable(ptr_q));

  // R10
  ptr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> (ptr_q == $past(wdata_i[IDX_W-1:0])));

  // R11
  ctrl_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> (rdata_o[6:3] == 4'b0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter  int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   irq_req_i,
  input  logic [2*N_SRC-1:0] irq_lvl_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_addr_i,
  input  logic [7:0]         csr_wdata_i,
  output logic [7:0]         csr_rdata_o,
  output logic               gnt_valid_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic [1:0]         gnt_lvl_o,
  input  logic               gnt_ack_i,
  input  logic               reti_i
);
  logic [2:0]                    en;
  logic                          rot;
  logic [IDX_W-1:0]              ptr;
  logic [NUM_LVL-1:0]            act;
  logic [NUM_LVL-1:0]            lvl_ok, lvl_hit;
  logic [NUM_LVL-1:0][N_SRC-1:0] lvl_req;
  logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx;
  logic                          ack_fire;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    if (l == int'(LVL_NMI)) begin : g_nmi
      assign lvl_ok[l] = ~act[l];
    end else begin : g_mask
      assign lvl_ok[l] = ~|act[NUM_LVL-1:l] & en[l];
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign lvl_req[l][s] = irq_req_i[s] && lvl_ok[l]
                             && (irq_lvl_i[2*s +: 2] == 2'(l));
    end

    irq_find_first #(.N(N_SRC)) u_scan (
      .vec_i   (lvl_req[l]),
      .start_i ((l == int'(LVL_LO)) ? ptr : '0),
      .found_o (lvl_hit[l]),
      .idx_o   (lvl_idx[l])
    );
  end

  // ascending walk: highest hit level overrides
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    gnt_lvl_o   = LVL_LO;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_hit[l]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = lvl_idx[l];
        gnt_lvl_o   = 2'(l);
      end
    end
  end

  assign ack_fire = gnt_ack_i && gnt_valid_o;

  irq_nest u_nest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_fire),
    .ack_lvl_i (gnt_lvl_o),
    .reti_i    (reti_i),
    .act_o     (act)
  );

  irq_prio_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .wdata_i   (csr_wdata_i),
    .ack_lo_i  (ack_fire && (gnt_lvl_o == LVL_LO)),
    .ack_idx_i (gnt_idx_o),
    .act_i     (act),
    .en_o      (en),
    .rot_o     (rot),
    .ptr_o     (ptr),
    .rdata_o   (csr_rdata_o)
  );

  // R2
  gnt_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && gnt_lvl_o != LVL_NMI) |-> en[gnt_lvl_o]);

  // R5
  gnt_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ((act >> gnt_lvl_o) == '0));

  // R12
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> irq_req_i[gnt_idx_o]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [2*N-1:0]  lvl = '0;
  logic            we = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [7:0]      wdata = 8'h00;
  logic            ack = 1'b0;
  logic            reti = 1'b0;
  logic [7:0]      rdata;
  logic            gv;
  logic [IW-1:0]   gidx;
  logic [1:0]      glvl;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  // reference state
  bit m_en[3];
  bit m_rot;
  int m_ptr;
  bit m_act[4];

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .irq_lvl_i(lvl),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .gnt_valid_o(gv), .gnt_idx_o(gidx), .gnt_lvl_o(glvl),
    .gnt_ack_i(ack), .reti_i(reti)
  );

  task automatic model_grant(output bit v, output int idx, output int lv);
    int top = -1;
    v = 0; idx = 0; lv = 0;
    for (int l = 0; l < 4; l++) if (m_act[l]) top = l;
    for (int l = 3; l >= 0; l--) begin
      if (v || l <= top) break;
      if (l != 3 && !m_en[l]) continue;
      for (int k = 0; k < N; k++) begin
        int s = (l == 0) ? (m_ptr + k) % N : k;
        if (req[s] && int'(lvl[2*s +: 2]) == l) begin
          v = 1; idx = s; lv = l;
          break;
        end
      end
    end
  endtask

  function automatic int model_rdata(input int a);
    case (a)
      0: return (m_act[3] << 3) | (m_act[2] << 2) | (m_act[1] << 1) | int'(m_act[0]);
      1: return m_ptr;
      2: return (m_rot << 7) | (m_en[2] << 2) | (m_en[1] << 1) | int'(m_en[0]);
      default: return 0;
    endcase
  endfunction

  // one clock: compare at negedge, then advance the model across the next posedge
  task automatic step(input string tag);
    bit v; int idx, lv, erd;
    bit old_rot;
    bit done;
    @(negedge clk);
    model_grant(v, idx, lv);
    erd = model_rdata(int'(addr));
    n_cmp++;
    if (gv !== v || (v && (int'(gidx) !== idx || int'(glvl) !== lv)) || int'(rdata) !== erd) begin
      n_bad++;
      $display("FAIL %s t=%0t: got v=%0b idx=%0d lvl=%0d rd=%02h exp v=%0b idx=%0d lvl=%0d rd=%02h",
               tag, $time, gv, gidx, glvl, rdata, v, idx, lv, erd[7:0]);
    end
    old_rot = m_rot;
    if (we && addr == 2'd2) begin
      m_en[0] = wdata[0]; m_en[1] = wdata[1]; m_en[2] = wdata[2]; m_rot = wdata[7];
    end
    if (we && addr == 2'd1) m_ptr = int'(wdata) % N;
    else if (ack && v && lv == 0 && old_rot) m_ptr = (idx + 1) % N;
    done = 0;
    if (reti) for (int l = 3; l >= 0; l--) if (!done && m_act[l]) begin m_act[l] = 0; done = 1; end
    if (ack && v) m_act[lv] = 1;
    @(posedge clk);
    #1;
    we = 1'b0; ack = 1'b0; reti = 1'b0;
  endtask

  task automatic set_src(input int s, input int l, input bit on);
    lvl[2*s +: 2] = 2'(l);
    req[s] = on;
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(tag);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values at each address, maskable request ignored
    set_src(2, 0, 1);
    addr = 2'd0; step("R1");
    addr = 2'd1; step("R1");
    addr = 2'd2; step("R1");
    addr = 2'd3; step("R11");
    // R2: non-maskable granted with all enables clear
    set_src(5, 3, 1);
    step("R2");
    set_src(5, 3, 0);
    // R3: enable write effective next cycle
    wr("R3", 2'd2, 8'h07);
    step("R3");
    wr("R3", 2'd2, 8'h06);
    step("R3");
    step("R2");
    wr("R3", 2'd2, 8'h07);
    // R4: high, medium and low mixed
    set_src(1, 0, 1); set_src(3, 1, 1); set_src(6, 2, 1); set_src(4, 2, 1);
    addr = 2'd0;
    step("R4");
    ack = 1'b1; step("R6");
    // R5: same level blocked, lower blocked
    set_src(4, 2, 0);
    step("R5");
    set_src(7, 3, 1);
    step("R5");
    ack = 1'b1; step("R6");
    set_src(7, 3, 0);
    step("R5");
    reti = 1'b1; step("R7");
    step("R7");
    reti = 1'b1; step("R7");
    set_src(6, 2, 0);
    step("R4");
    // R7: return and acknowledge together
    ack = 1'b1; step("R6");
    set_src(6, 2, 1);
    step("R5");
    ack = 1'b1; reti = 1'b1; step("R7");
    step("R7");
    reti = 1'b1; step("R7");
    reti = 1'b1; step("R7");
    set_src(6, 2, 0); set_src(3, 1, 0); set_src(1, 0, 0); set_src(2, 0, 0);
    step("R7");
    // R8: pointer-based low search, rotation off
    set_src(2, 0, 1); set_src(6, 0, 1);
    addr = 2'd1;
    wr("R10", 2'd1, 8'h05);
    step("R8");
    wr("R10", 2'd1, 8'h00);
    step("R8");
    wr("R10", 2'd1, 8'h0F);
    step("R8");
    ack = 1'b1; step("R9");
    step("R9");
    reti = 1'b1; step("R7");
    wr("R10", 2'd1, 8'h00);
    // R9: rotation sequence with wrap
    set_src(2, 0, 0); set_src(6, 0, 0);
    set_src(0, 0, 1); set_src(3, 0, 1); set_src(5, 0, 1);
    wr("R11", 2'd2, 8'h87);
    for (int i = 0; i < 5; i++) begin
      step("R9");
      ack = 1'b1; step("R9");
      reti = 1'b1; step("R9");
    end
    set_src(0, 0, 0); set_src(3, 0, 0); set_src(5, 0, 0); set_src(7, 0, 1);
    step("R12");
    ack = 1'b1; step("R9");
    step("R9");
    reti = 1'b1; step("R9");
    // R10: software write beats rotation update
    wr("R10", 2'd1, 8'h03);
    ack = 1'b1; we = 1'b1; addr = 2'd1; wdata = 8'h06; step("R10");
    step("R10");
    reti = 1'b1; step("R10");
    // R10: pointer kept when rotation off, acks do not move it
    wr("R10", 2'd2, 8'h07);
    step("R10");
    ack = 1'b1; step("R9");
    step("R9");
    reti = 1'b1; step("R9");
    set_src(7, 0, 0);
    // R11: reserved bits, ignored addresses
    wr("R11", 2'd2, 8'hFF);
    addr = 2'd2; step("R11");
    set_src(1, 1, 1);
    ack = 1'b1; step("R6");
    wr("R11", 2'd0, 8'hFF);
    addr = 2'd0; step("R11");
    wr("R11", 2'd3, 8'hFF);
    addr = 2'd3; step("R11");
    addr = 2'd1; step("R11");
    addr = 2'd2; step("R11");
    reti = 1'b1; step("R7");
    set_src(1, 1, 0);
    step("R12");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule